// File: doc/BRIEF.md
# CAN Transmit Buffer Abort Controller

This block manages the withdrawal of queued messages from the transmit buffers of a CAN controller. Software schedules a buffer by clearing its empty flag and may then ask, through a byte-wide register port, for that buffer to be pulled back before it goes out. A request is honoured at once when the buffer is idle. A buffer that is already on the bus finishes its attempt, and the request is honoured only if that attempt fails through lost arbitration or an error. A successful transmission simply empties the buffer. In that case no abort is acknowledged.

On an abort the buffer's empty flag and its abort-acknowledge flag are both set. The transmit interrupt is the OR, over all buffers, of each empty flag masked by its enable bit. Request bits can only be set by software and clear themselves when the buffer becomes empty. While the controller sits in initialization mode the request register is held cleared. The transmit engine drives a busy level per buffer and single-cycle end-of-attempt pulses (success, arbitration lost, error). It reads the empty flags back to know which buffers are queued.

Top module: `tabort_ctrl`

## Requirements
- R1: After reset, the four registers read as follows. Address 0 holds the empty flags and reads 0x07. Address 1 holds the interrupt enables and reads 0x00. Address 2 holds the abort requests and reads 0x00. Address 3 holds the abort acknowledges and reads 0x00. Buffer n sits in bit n (n = 0..2), and bits 7..3 of every register always read 0.
- R2: Writing 1 to bit n of address 2 sets request n when buffer n is scheduled (empty flag 0). Writing 0 has no effect. A 1 written for a buffer whose empty flag is 1 leaves no pending request.
- R3: A pending request on a scheduled buffer whose busy input is low is granted at the next clock edge. Its empty flag and acknowledge flag become 1 and the request clears.
- R4: While a buffer's busy input is high and no end pulse arrives, a pending request does not empty it. An arbitration-lost or error pulse for that buffer while the request is pending sets its empty and acknowledge flags at the next edge.
- R5: A success pulse for a scheduled buffer sets its empty flag at the next edge, clears any pending request, and leaves its acknowledge flag at 0.
- R6: A request bit is never 1 while the empty flag of the same buffer is 1.
- R7: Request writes are accepted only when both initialization inputs are low. While both are high, all request bits are cleared at the next edge and stay 0.
- R8: Writing 1 to bit n of address 0 while buffer n is empty schedules it: its empty flag and its acknowledge flag both become 0.
- R9: The interrupt output equals the OR over n of (empty flag n AND enable bit n). Enable bits are written at address 1.
- R10: An arbitration-lost or error pulse for a scheduled buffer with no pending request changes none of its flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 empty, 1 enable, 2 request, 3 acknowledge) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, upper bits zero |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| tx_busy | input | 3 | Per buffer: message currently on the bus |
| tx_ok | input | 3 | Per buffer: pulse, attempt ended successfully |
| tx_arb_lost | input | 3 | Per buffer: pulse, attempt ended with lost arbitration |
| tx_err | input | 3 | Per buffer: pulse, attempt ended with an error |
| buf_empty | output | 3 | Empty flags, scheduled buffers shown as 0 |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The hardest case to reach is a request that stays pending on a buffer in mid-transmission and is then resolved by the end pulse. The buffer must be scheduled, its busy input raised, and the request written while busy stays high. The register state is read across several idle cycles before the pulse is delivered. Failure and success endings are each driven this way, and so is a failure with no request pending. Initialization gating is checked the same way: one initialization input is raised on its own while the buffer is busy, which shows that writes are refused even though nothing is yet cleared.

// File: rtl/tabort_pkg.sv
package tabort_pkg;

    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_EMPTY = 2'd0;
    localparam logic [ADDR_W-1:0] A_IEN   = 2'd1;
    localparam logic [ADDR_W-1:0] A_REQ   = 2'd2;
    localparam logic [ADDR_W-1:0] A_ACK   = 2'd3;

    typedef struct packed {
        logic empty;
        logic ack;
        logic req;
    } slot_t;

    localparam slot_t SLOT_RESET = '{empty: 1'b1, ack: 1'b0, req: 1'b0};

endpackage

// File: rtl/tabort_mode.sv
module tabort_mode (
    input  logic init_req,
    input  logic init_ack,
    output logic hold,
    output logic write_ok
);
    // Held in reset only when both handshake halves agree on init mode.
    assign hold     = init_req & init_ack;
    // Writable only once both halves have left init mode.
    assign write_ok = ~init_req & ~init_ack;
endmodule

// File: rtl/tabort_slot.sv
module tabort_slot
    import tabort_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sched_wr,
    input  logic abort_wr,
    input  logic hold,
    input  logic busy,
    input  logic end_ok,
    input  logic end_arb,
    input  logic end_err,
    output logic empty,
    output logic ack,
    output logic req
);
    slot_t s_d, s_q;

    logic fin_ok, fin_fail, idle_grant;

    always_comb begin
        s_d        = s_q;
        fin_ok     = end_ok & ~s_q.empty;
        fin_fail   = (end_arb | end_err) & ~end_ok & ~s_q.empty;
        idle_grant = s_q.req & ~s_q.empty & ~busy;

        if (sched_wr && s_q.empty) begin
            s_d.empty = 1'b0;
            s_d.ack   = 1'b0;
        end

        if (abort_wr && !s_q.empty) begin
            s_d.req = 1'b1;
        end

        if (fin_ok) begin
            s_d.empty = 1'b1;
        end else if (fin_fail && s_q.req) begin
            s_d.empty = 1'b1;
            s_d.ack   = 1'b1;
        end else if (idle_grant && !fin_fail) begin
            s_d.empty = 1'b1;
            s_d.ack   = 1'b1;
        end

        if (s_d.empty) begin
            s_d.req = 1'b0;
        end
        if (hold) begin
            s_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SLOT_RESET;
        else        s_q <= s_d;
    end

    assign empty = s_q.empty;
    assign ack   = s_q.ack;
    assign req   = s_q.req;
endmodule

// File: rtl/tabort_regif.sv
module tabort_regif
    import tabort_pkg::*;
#(
    parameter int unsigned NBUF = 3,
    parameter int unsigned DW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              write_ok,
    input  logic [NBUF-1:0]   empty,
    input  logic [NBUF-1:0]   req,
    input  logic [NBUF-1:0]   ack,
    output logic [NBUF-1:0]   sched_wr,
    output logic [NBUF-1:0]   abort_wr,
    output logic [NBUF-1:0]   ien,
    output logic [DW-1:0]     rdata
);
    typedef struct packed {
        logic [NBUF-1:0] ien;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        sched_wr = '0;
        abort_wr = '0;
        if (wr) begin
            unique case (addr)
                A_EMPTY: sched_wr = wdata[NBUF-1:0];
                A_IEN:   r_d.ien  = wdata[NBUF-1:0];
                A_REQ:   abort_wr = write_ok ? wdata[NBUF-1:0] : '0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ien = r_q.ien;

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_EMPTY: rdata[NBUF-1:0] = empty;
            A_IEN:   rdata[NBUF-1:0] = r_q.ien;
            A_REQ:   rdata[NBUF-1:0] = req;
            default: rdata[NBUF-1:0] = ack;
        endcase
    end
endmodule

// File: rtl/tabort_ctrl.sv
module tabort_ctrl
    import tabort_pkg::*;
#(
    parameter int unsigned NBUF = 3,
    parameter int unsigned DW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              init_req,
    input  logic              init_ack,
    input  logic [NBUF-1:0]   tx_busy,
    input  logic [NBUF-1:0]   tx_ok,
    input  logic [NBUF-1:0]   tx_arb_lost,
    input  logic [NBUF-1:0]   tx_err,
    output logic [NBUF-1:0]   buf_empty,
    output logic              tx_irq
);
    logic            hold, write_ok;
    logic [NBUF-1:0] sched_wr, abort_wr, ien_w;
    logic [NBUF-1:0] empty_w, ack_w, req_w;

    tabort_mode u_mode (
        .init_req (init_req),
        .init_ack (init_ack),
        .hold     (hold),
        .write_ok (write_ok)
    );

    tabort_regif #(.NBUF(NBUF), .DW(DW)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .write_ok (write_ok),
        .empty    (empty_w),
        .req      (req_w),
        .ack      (ack_w),
        .sched_wr (sched_wr),
        .abort_wr (abort_wr),
        .ien      (ien_w),
        .rdata    (reg_rdata)
    );

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        tabort_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .sched_wr (sched_wr[i]),
            .abort_wr (abort_wr[i]),
            .hold     (hold),
            .busy     (tx_busy[i]),
            .end_ok   (tx_ok[i]),
            .end_arb  (tx_arb_lost[i]),
            .end_err  (tx_err[i]),
            .empty    (empty_w[i]),
            .ack      (ack_w[i]),
            .req      (req_w[i])
        );
    end

    assign buf_empty = empty_w;
    assign tx_irq    = |(empty_w & ien_w);
endmodule

// File: rtl/tabort_ctrl_chk.sv
module tabort_ctrl_chk #(
    parameter int unsigned NBUF = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            init_req,
    input logic            init_ack,
    input logic [NBUF-1:0] tx_busy,
    input logic [NBUF-1:0] tx_ok,
    input logic [NBUF-1:0] tx_arb_lost,
    input logic [NBUF-1:0] tx_err,
    input logic [NBUF-1:0] empty,
    input logic [NBUF-1:0] ack,
    input logic [NBUF-1:0] req
);
    // R7
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && init_ack) |=> (req == '0));

    for (genvar i = 0; i < NBUF; i++) begin : g_chk
        // R6
        req_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(req[i] && empty[i]));

        // R3
        idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req[i] && !empty[i] && !tx_busy[i] && !tx_ok[i]) |=> (empty[i] && ack[i] && !req[i]));

        // R4
        busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req[i] && !empty[i] && tx_busy[i] && !tx_ok[i] && !tx_arb_lost[i] && !tx_err[i])
            |=> !empty[i]);

        // R4
        fail_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req[i] && !empty[i] && !tx_ok[i] && (tx_arb_lost[i] || tx_err[i]))
            |=> (empty[i] && ack[i]));

        // R5
        ok_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_ok[i] && !empty[i]) |=> (empty[i] && !ack[i] && !req[i]));

        // R10
        fail_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!req[i] && !empty[i] && !tx_ok[i] && (tx_arb_lost[i] || tx_err[i]))
            |=> !empty[i]);
    end
endmodule

bind tabort_ctrl tabort_ctrl_chk #(.NBUF(NBUF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_req    (init_req),
    .init_ack    (init_ack),
    .tx_busy     (tx_busy),
    .tx_ok       (tx_ok),
    .tx_arb_lost (tx_arb_lost),
    .tx_err      (tx_err),
    .empty       (empty_w),
    .ack         (ack_w),
    .req         (req_w)
);

// File: tb/tabort_ctrl_test.sv
module tabort_ctrl_test;
    localparam int NB = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       init_req = 1'b0;
    logic       init_ack = 1'b0;
    logic [NB-1:0] tx_busy = '0, tx_ok = '0, tx_arb_lost = '0, tx_err = '0;
    logic [NB-1:0] buf_empty;
    logic       tx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tabort_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .init_req(init_req),
        .init_ack(init_ack), .tx_busy(tx_busy), .tx_ok(tx_ok),
        .tx_arb_lost(tx_arb_lost), .tx_err(tx_err), .buf_empty(buf_empty),
        .tx_irq(tx_irq)
    );

    // sel 0..3: register address, 4: interrupt pin, 5: buf_empty pins
    typedef struct {
        int       sel;
        logic [7:0] exp;
        string    tag;
    } item_t;

    item_t sb[$];

    // Driver side: point the read port at the target and queue the expectation.
    task automatic chk(input int sel, input logic [7:0] exp, input string tag);
        item_t it;
        if (sel < 4) reg_addr = sel[1:0];
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        #2;
    endtask

    // Monitor side: pop each expectation and compare against the design.
    initial begin
        forever begin
            item_t it;
            logic [7:0] got;
            wait (sb.size() > 0);
            #1;
            it = sb.pop_front();
            if (it.sel == 4)      got = {7'd0, tx_irq};
            else if (it.sel == 5) got = {5'd0, buf_empty};
            else                  got = reg_rdata;
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: got %02h expected %02h", it.tag, got, it.exp);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int kind, input int idx);
        @(negedge clk);
        case (kind)
            0: tx_ok[idx] = 1'b1;
            1: tx_arb_lost[idx] = 1'b1;
            default: tx_err[idx] = 1'b1;
        endcase
        @(negedge clk);
        tx_ok = '0; tx_arb_lost = '0; tx_err = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1 reset state and layout
        chk(0, 8'h07, "R1 empty reset");
        chk(1, 8'h00, "R1 ien reset");
        chk(2, 8'h00, "R1 req reset");
        chk(3, 8'h00, "R1 ack reset");
        chk(4, 8'h00, "R9 irq reset");
        wr(2'd1, 8'hFF);
        chk(1, 8'h07, "R1 upper bits read zero");
        chk(4, 8'h01, "R9 irq all enabled");
        wr(2'd1, 8'h00);
        chk(4, 8'h00, "R9 irq all masked");

        // R8 schedule, R2 ignored requests
        wr(2'd0, 8'h01);
        chk(0, 8'h06, "R8 schedule B0");
        chk(5, 8'h06, "R8 buf_empty pins");
        wr(2'd2, 8'h06);
        chk(2, 8'h00, "R2 request on empty buffers ignored");
        wr(2'd2, 8'h00);
        chk(2, 8'h00, "R2 zero write no effect");

        // R3 idle grant
        wr(2'd2, 8'h01);
        chk(2, 8'h01, "R2 request pending");
        step(1);
        chk(0, 8'h07, "R3 idle grant empty");
        chk(3, 8'h01, "R3 idle grant ack");
        chk(2, 8'h00, "R3 request cleared");

        // R8 reschedule clears ack
        wr(2'd0, 8'h01);
        chk(3, 8'h00, "R8 ack cleared on schedule");

        // R4 busy hold then arbitration loss
        @(negedge clk); tx_busy[0] = 1'b1;
        wr(2'd2, 8'h01);
        step(2);
        chk(0, 8'h06, "R4 busy buffer not emptied");
        chk(2, 8'h01, "R4 request stays pending");
        pulse(1, 0);
        chk(0, 8'h07, "R4 arb loss grants empty");
        chk(3, 8'h01, "R4 arb loss grants ack");
        chk(2, 8'h00, "R6 request cleared with empty");
        tx_busy[0] = 1'b0;

        // R4 error ending
        wr(2'd0, 8'h02);
        @(negedge clk); tx_busy[1] = 1'b1;
        wr(2'd2, 8'h02);
        step(1);
        chk(0, 8'h05, "R4 B1 still scheduled");
        pulse(2, 1);
        chk(3, 8'h03, "R4 error grants ack");
        chk(0, 8'h07, "R4 error grants empty");
        tx_busy[1] = 1'b0;

        // R5 success with pending request
        wr(2'd0, 8'h04);
        @(negedge clk); tx_busy[2] = 1'b1;
        wr(2'd2, 8'h04);
        chk(2, 8'h04, "R5 request pending");
        pulse(0, 2);
        chk(0, 8'h07, "R5 success empties");
        chk(3, 8'h03, "R5 no ack on success");
        chk(2, 8'h00, "R5 request cleared");
        tx_busy[2] = 1'b0;

        // R10 failure without request
        wr(2'd0, 8'h01);
        @(negedge clk); tx_busy[0] = 1'b1;
        pulse(1, 0);
        chk(0, 8'h06, "R10 arb loss no request keeps scheduled");
        chk(3, 8'h02, "R10 ack unchanged");
        pulse(2, 0);
        chk(0, 8'h06, "R10 error no request keeps scheduled");
        pulse(0, 0);
        chk(0, 8'h07, "R5 retry success");

        // R7 init gating
        @(negedge clk); init_req = 1'b1;
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h01);
        chk(2, 8'h00, "R7 write refused with one init input high");
        init_req = 1'b0;
        wr(2'd2, 8'h01);
        chk(2, 8'h01, "R7 write accepted out of init");
        init_req = 1'b1; init_ack = 1'b1;
        step(1);
        chk(2, 8'h00, "R7 request cleared in init");
        wr(2'd2, 8'h01);
        chk(2, 8'h00, "R7 request held clear in init");
        init_req = 1'b0; init_ack = 1'b0;
        chk(0, 8'h06, "R7 buffer still scheduled");
        pulse(0, 0);
        tx_busy[0] = 1'b0;
        chk(0, 8'h07, "R5 buffer emptied");

        // R9 masked interrupt
        wr(2'd1, 8'h01);
        chk(4, 8'h01, "R9 irq enabled empty B0");
        wr(2'd0, 8'h01);
        chk(4, 8'h00, "R9 irq others masked");
        pulse(0, 0);
        chk(4, 8'h01, "R9 irq on success");

        step(2);
        wait (sb.size() == 0);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule